// File: doc/BRIEF.md
# Two-Wire Slave Address Match and Acknowledge Decision

This block is the part of a two-wire serial controller that works out, for each byte received on the bus, whether the device should answer. It looks at the first byte after every START or repeated START. It compares the upper seven bits of that byte with a programmed own address. If it is enabled, it also recognises the all-zero general call byte. From this comparison it chooses the level driven on the data line in the acknowledge slot that follows. On a hit, the direction bit of the byte chooses whether the device goes on as a slave receiver or as a slave transmitter.

For the bytes that follow, it acknowledges received data when the device is a master receiver or an addressed slave receiver. The choice between ACK and NOT ACK follows a single acknowledge-enable input. The same input, when low, makes the device ignore its address completely. Bit shifting, clock stretching and START/STOP detection live elsewhere. This block only sees a START strobe, a byte-complete strobe with the eight received bits, and the bus role chosen by the controller.

All outputs are registered. A decision made in the byte-complete cycle shows on the outputs in the next cycle and is held for the whole ninth-bit slot.

Top module: `twi_addr_ack`

## Requirements
- R1: After synchronous reset, `sda_ack`=1, `match_evt`=0, `gen_call`=0 and `slv_tx`=0. The address register resets to 0xFE, which is own address 0x7F with general call disabled.
- R2: A cycle with `cfg_load`=1 loads `cfg_wdata` into the address register. Bits 7:1 are the own address and bit 0 enables general call recognition.
- R3: In slave role (`role`=0) with `ack_en`=1, a first byte after START whose bits 7:1 equal the own address has this effect in the cycle after `byte_done`: `sda_ack`=0 and `match_evt`=1. `match_evt` lasts exactly one cycle.
- R4: After a match, `slv_tx` takes bit 0 of the address byte (0 = slave receiver, 1 = slave transmitter) and holds it until the next START.
- R5: The byte 0x00 is a general call only when bit 0 of the address register is 1. It then matches with `gen_call`=1 and `slv_tx`=0. When that bit is 0, or for the byte 0x01, there is no general call match.
- R6: With `ack_en`=0, no byte is acknowledged and no address match is raised. Raising `ack_en` again takes effect on address recognition from the next START.
- R7: In the slave receiver state, each data byte gives `sda_ack` = NOT `ack_en`, with `ack_en` sampled in the `byte_done` cycle.
- R8: In master receiver role (`role`=2), the first byte after START is never compared and is released. Each later byte gives `sda_ack` = NOT `ack_en`.
- R9: Bytes are released (`sda_ack`=1) in the slave transmitter state, in the unaddressed state and in master transmitter role (`role`=1 or 3).
- R10: `sda_ack` changes only in the cycle after a `byte_done` or `start_det`. Otherwise it holds its value.
- R11: `start_det` releases `sda_ack`, clears `gen_call` and `slv_tx`, and arms comparison of the next byte. It takes priority over a `byte_done` in the same cycle, which is then discarded.
- R12: A first byte that matches neither address is released without `match_evt`. All bytes up to the next START are also released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for the address register |
| cfg_wdata | input | 8 | Value for the address register: own address in 7:1, general call enable in 0 |
| ack_en | input | 1 | Acknowledge enable; low disconnects the device from addressing |
| role | input | 2 | Bus role: 0 slave side, 1 master transmitter, 2 master receiver, 3 as 1 |
| start_det | input | 1 | One-cycle strobe: START or repeated START seen |
| byte_done | input | 1 | One-cycle strobe: eight bits received in `rx_byte` |
| rx_byte | input | 8 | Received byte, address in 7:1 and direction in 0 for address bytes |
| match_evt | output | 1 | One-cycle event: own address or general call matched |
| gen_call | output | 1 | Current transfer was opened by a general call |
| slv_tx | output | 1 | Addressed as slave transmitter |
| sda_ack | output | 1 | Acknowledge level: 0 pulls the data line low (ACK), 1 releases it |

## Verification
A START strobe and a byte-complete strobe can arrive in the same cycle, because a repeated START can be seen just as the bytes of a transfer end. The bench raises both together while the device is addressed and holds an ACK, with a byte that would match the own address. The cycle after must show a released data line, no match event and a cleared direction. The next byte alone must then be taken as the address, which shows that the START was honoured and the byte was dropped. The bench also changes the acknowledge enable between bytes, to judge that each data byte follows the value present in its own strobe cycle.

// File: rtl/twi_aa_pkg.sv
package twi_aa_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam logic [BYTE_W-1:0] CFG_RST = 8'hFE;

    // bus role supplied by the controller
    localparam logic [1:0] ROLE_SLAVE = 2'd0;
    localparam logic [1:0] ROLE_MTX   = 2'd1;
    localparam logic [1:0] ROLE_MRX   = 2'd2;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_RX   = 2'd1,
        SL_TX   = 2'd2
    } slv_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] own;
        logic              gce;
    } addr_cfg_t;

    typedef struct packed {
        logic own_hit;
        logic gc_hit;
        logic rd;
    } cmp_res_t;

    // ACK decision for a byte that is not an address byte
    function automatic logic ack_for_data(input logic [1:0] role_v,
                                          input slv_state_e st_v,
                                          input logic ack_en_v);
        logic rx_side;
        rx_side = (role_v == ROLE_MRX) ||
                  ((role_v == ROLE_SLAVE) && (st_v == SL_RX));
        return ack_en_v && rx_side;
    endfunction

endpackage

// File: rtl/twi_aa_cfg_reg.sv
module twi_aa_cfg_reg
    import twi_aa_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter logic [W-1:0] RST_VAL = CFG_RST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (load) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/twi_aa_addr_cmp.sv
module twi_aa_addr_cmp
    import twi_aa_pkg::*;
(
    input  addr_cfg_t         cfg,
    input  logic [BYTE_W-1:0] rx,
    output cmp_res_t          res
);

    logic zero_byte;

    always_comb begin
        zero_byte   = (rx == '0);
        res.gc_hit  = cfg.gce && zero_byte;
        // a general call is reported as such even if own address is zero
        res.own_hit = !res.gc_hit && (rx[BYTE_W-1:1] == cfg.own);
        res.rd      = rx[0];
    end

endmodule

// File: rtl/twi_aa_ack_ctl.sv
module twi_aa_ack_ctl
    import twi_aa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack_en,
    input  logic [1:0] role,
    input  logic       start_det,
    input  logic       byte_done,
    input  cmp_res_t   cmp,
    output logic       match_evt,
    output logic       gen_call,
    output logic       slv_tx,
    output logic       sda_ack
);

    logic       expect_addr;
    slv_state_e st;
    logic       hit;
    logic       data_ack;

    always_comb begin
        hit      = ack_en && (cmp.own_hit || cmp.gc_hit);
        data_ack = ack_for_data(role, st, ack_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_addr <= 1'b0;
            st          <= SL_IDLE;
            match_evt   <= 1'b0;
            gen_call    <= 1'b0;
            slv_tx      <= 1'b0;
            sda_ack     <= 1'b1;
        end else begin
            match_evt <= 1'b0;
            if (start_det) begin
                expect_addr <= 1'b1;
                st          <= SL_IDLE;
                gen_call    <= 1'b0;
                slv_tx      <= 1'b0;
                sda_ack     <= 1'b1;
            end else if (byte_done) begin
                expect_addr <= 1'b0;
                if (expect_addr) begin
                    if ((role == ROLE_SLAVE) && hit) begin
                        st        <= cmp.rd ? SL_TX : SL_RX;
                        match_evt <= 1'b1;
                        gen_call  <= cmp.gc_hit;
                        slv_tx    <= cmp.rd;
                        sda_ack   <= 1'b0;
                    end else begin
                        st      <= SL_IDLE;
                        sda_ack <= 1'b1;
                    end
                end else begin
                    sda_ack <= !data_ack;
                end
            end
        end
    end

    assert_start_release_R11: assert property (@(posedge clk) disable iff (rst)
        $past(start_det) |-> (sda_ack && !match_evt && !gen_call && !slv_tx));

    assert_noack_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        $past(byte_done && !start_det && !ack_en) |-> (sda_ack && !match_evt));

    assert_ack_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(byte_done) && !$past(start_det)) |-> $stable(sda_ack));

    assert_match_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> !match_evt);

    assert_match_ack_R3: assert property (@(posedge clk) disable iff (rst)
        match_evt |-> (!sda_ack && $past(byte_done)));

    assert_gc_write_R5: assert property (@(posedge clk) disable iff (rst)
        gen_call |-> !slv_tx);

    assert_tx_release_R9: assert property (@(posedge clk) disable iff (rst)
        (byte_done && !start_det && !expect_addr && slv_tx) |=> sda_ack);

endmodule

// File: rtl/twi_addr_ack.sv
module twi_addr_ack
    import twi_aa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              ack_en,
    input  logic [1:0]        role,
    input  logic              start_det,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              match_evt,
    output logic              gen_call,
    output logic              slv_tx,
    output logic              sda_ack
);

    logic [BYTE_W-1:0] cfg_q;
    addr_cfg_t         cfg_s;
    cmp_res_t          cmp_s;

    twi_aa_cfg_reg #(.W(BYTE_W), .RST_VAL(CFG_RST)) cfg_i (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_load),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    assign cfg_s = cfg_q;

    twi_aa_addr_cmp cmp_i (
        .cfg (cfg_s),
        .rx  (rx_byte),
        .res (cmp_s)
    );

    twi_aa_ack_ctl ctl_i (
        .clk       (clk),
        .rst       (rst),
        .ack_en    (ack_en),
        .role      (role),
        .start_det (start_det),
        .byte_done (byte_done),
        .cmp       (cmp_s),
        .match_evt (match_evt),
        .gen_call  (gen_call),
        .slv_tx    (slv_tx),
        .sda_ack   (sda_ack)
    );

endmodule

// File: tb/twi_addr_ack_tb.sv
module twi_addr_ack_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       ack_en = 1'b1;
    logic [1:0] role = 2'd0;
    logic       start_det = 1'b0;
    logic       byte_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       match_evt, gen_call, slv_tx, sda_ack;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_addr_ack dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_wdata(cfg_wdata),
        .ack_en(ack_en), .role(role), .start_det(start_det),
        .byte_done(byte_done), .rx_byte(rx_byte), .match_evt(match_evt),
        .gen_call(gen_call), .slv_tx(slv_tx), .sda_ack(sda_ack)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); rx_byte = b; byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0;
    endtask

    task automatic do_cfg(input logic [7:0] v);
        @(negedge clk); cfg_wdata = v; cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 sda_ack after reset", sda_ack, 1'b1);
        check("R1 match_evt after reset", match_evt, 1'b0);
        check("R1 gen_call after reset", gen_call, 1'b0);
        check("R1 slv_tx after reset", slv_tx, 1'b0);
        do_start(); do_byte(8'hFE);
        check("R1 reset address 0x7F acked", sda_ack, 1'b0);
        check("R1 reset address match", match_evt, 1'b1);
        do_start(); do_byte(8'h00);
        check("R1 general call off at reset", sda_ack, 1'b1);
        check("R5 no gc match when disabled", match_evt, 1'b0);
    endtask

    task automatic t_cfg();
        do_cfg(8'h54);
        do_start(); do_byte(8'h54);
        check("R2 loaded address acked", sda_ack, 1'b0);
        check("R2 loaded address match", match_evt, 1'b1);
        do_start(); do_byte(8'hFE);
        check("R2 old address no longer acked", sda_ack, 1'b1);
    endtask

    task automatic t_slave_rx();
        do_start(); do_byte(8'h54);
        check("R4 write bit gives receiver", slv_tx, 1'b0);
        check("R3 match raised", match_evt, 1'b1);
        @(negedge clk);
        check("R3 match one cycle", match_evt, 1'b0);
        do_byte(8'h12);
        check("R7 data acked with ack_en=1", sda_ack, 1'b0);
        check("R3 no match on data", match_evt, 1'b0);
        ack_en = 1'b0;
        do_byte(8'h34);
        check("R7 data nacked with ack_en=0", sda_ack, 1'b1);
        ack_en = 1'b1;
        do_byte(8'h56);
        check("R7 data acked again", sda_ack, 1'b0);
    endtask

    task automatic t_slave_tx();
        do_start(); do_byte(8'h55);
        check("R3 read address acked", sda_ack, 1'b0);
        check("R4 read bit gives transmitter", slv_tx, 1'b1);
        do_byte(8'hA5);
        check("R9 slave transmitter releases", sda_ack, 1'b1);
        check("R4 direction held", slv_tx, 1'b1);
    endtask

    task automatic t_gen_call();
        do_cfg(8'h55);
        do_start(); do_byte(8'h00);
        check("R5 gc acked", sda_ack, 1'b0);
        check("R5 gc flag", gen_call, 1'b1);
        check("R5 gc match", match_evt, 1'b1);
        check("R5 gc is write", slv_tx, 1'b0);
        do_byte(8'h77);
        check("R7 gc data acked", sda_ack, 1'b0);
        do_start(); do_byte(8'h01);
        check("R5 0x01 not gc", sda_ack, 1'b1);
        check("R5 0x01 no gc flag", gen_call, 1'b0);
    endtask

    task automatic t_ack_disable();
        ack_en = 1'b0;
        do_start(); do_byte(8'h54);
        check("R6 own address ignored", sda_ack, 1'b1);
        check("R6 no match when disabled", match_evt, 1'b0);
        do_byte(8'h11);
        check("R6 data not acked", sda_ack, 1'b1);
        ack_en = 1'b1;
        do_byte(8'h22);
        check("R6 still unaddressed until START", sda_ack, 1'b1);
        do_start(); do_byte(8'h54);
        check("R6 recognition resumed", sda_ack, 1'b0);
    endtask

    task automatic t_mismatch();
        do_start(); do_byte(8'h56);
        check("R12 other address released", sda_ack, 1'b1);
        check("R12 no match", match_evt, 1'b0);
        do_byte(8'h33);
        check("R12 following data released", sda_ack, 1'b1);
    endtask

    task automatic t_master();
        role = 2'd2;
        do_start(); do_byte(8'h54);
        check("R8 address byte not compared", match_evt, 1'b0);
        check("R8 address byte released", sda_ack, 1'b1);
        do_byte(8'h9C);
        check("R8 master rx ack", sda_ack, 1'b0);
        ack_en = 1'b0;
        do_byte(8'h9D);
        check("R8 master rx nack", sda_ack, 1'b1);
        ack_en = 1'b1;
        role = 2'd1;
        do_byte(8'h9E);
        check("R9 master tx releases", sda_ack, 1'b1);
        role = 2'd0;
    endtask

    task automatic t_hold_collide();
        do_start(); do_byte(8'h54);
        repeat (5) @(negedge clk);
        check("R10 ack held", sda_ack, 1'b0);
        @(negedge clk); rx_byte = 8'h54; byte_done = 1'b1; start_det = 1'b1;
        @(negedge clk); byte_done = 1'b0; start_det = 1'b0;
        check("R11 start wins: released", sda_ack, 1'b1);
        check("R11 start wins: no match", match_evt, 1'b0);
        do_byte(8'h55);
        check("R11 next byte is address", match_evt, 1'b1);
        check("R11 direction from new address", slv_tx, 1'b1);
        do_start();
        check("R11 start releases held ack", sda_ack, 1'b1);
        check("R11 start clears direction", slv_tx, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_slave_rx();
        t_slave_tx();
        t_gen_call();
        do_cfg(8'h54);
        t_ack_disable();
        t_mismatch();
        t_master();
        t_hold_collide();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule